// File: doc/BRIEF.md
# Per-ID Destination Thread Gate

This block sits on one slave-side port of a multi-destination interconnect and decides whether an address request may enter. It keeps a small pool of thread slots. Each slot holds a transaction ID, the destination index that ID is bound to, and how many transactions on that ID are still outstanding. A request either joins the slot already holding its ID, if the destination is the same, or takes a free slot. A request is refused while its ID is in flight toward another destination. It is also refused when no slot is left. Holding these requests back means responses for one ID can never return out of order from two different downstream ports.

A completion input reports the ID of each finished transaction and decrements the matching slot. A slot goes back to free when its count reaches zero. Each interface instantiates its own copy, so running out of slots on one port never affects another. Every slot runs a two-state machine. In `TH_FREE` the only transition is `T_ALLOC` to `TH_BUSY`, taken when the slot is picked for a new ID. In `TH_BUSY` the transitions are `T_JOIN` (count up), `T_RETIRE` (count down), `T_JOIN_RETIRE` (join and completion in the same cycle, count held) and `T_DRAIN` (last completion, back to `TH_FREE`).

Top module: `axi_id_thread_gate`

## Requirements
- R1: Synchronous active-low reset frees every slot and clears all counts and the error flag. After reset, `busy_map` reads all zeros and any request sees `req_ready` high.
- R2: A request whose ID is held by no busy slot is accepted while any slot is free. It takes the free slot with the lowest index, and bit i of `busy_map` is set from the next cycle.
- R3: A request whose ID and destination match a busy slot joins that slot. The slot's count saturates at `CNT_MAX`, and while the count is at `CNT_MAX`, a further request on that ID sees `req_ready` low.
- R4: A request whose ID is busy toward a different destination sees `req_ready` low. It is accepted in the cycle after the last outstanding transaction on that ID completes.
- R5: A request with a new ID sees `req_ready` low while all `NUM_THREADS` slots are busy.
- R6: A completion decrements the busy slot holding its ID. When the count reaches zero, the slot's `busy_map` bit clears on the next cycle.
- R7: An accepted join and a completion on the same slot in one cycle leave the count unchanged, and the slot stays busy.
- R8: A completion whose ID matches no busy slot changes no slot. It sets `err_unmatched`, which stays high until reset.
- R9: Requests on up to `NUM_THREADS` different IDs are outstanding at once. Their completions may arrive in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address request present |
| req_id | input | ID_W | Request transaction ID |
| req_dest | input | DEST_W | Decoded destination index |
| req_ready | output | 1 | Request may be accepted this cycle |
| cpl_valid | input | 1 | A transaction finished |
| cpl_id | input | ID_W | ID of the finished transaction |
| busy_map | output | NUM_THREADS | Bit i high while slot i is busy |
| err_unmatched | output | 1 | Sticky: a completion matched no busy slot |

## Verification
The bench targets the following corner cases:
- Saturating a slot. A design without the limit would wrap the count and free the slot while transactions are still in flight.
- The same ID toward a second destination, checked both just before and just after the drain. A design that ignores the destination would let responses reorder. One that checks the wrong count would stall forever.
- A full pool. A design with a wrong free search would overwrite a live slot.
- Re-allocation into a hole in the middle of the pool, which exposes a wrong priority order.
- A join and a completion landing together, both at count 1 and at a higher count. A design that lets the completion win frees a slot that is still in use.
- Stray completions, including a repeat completion after its slot has drained. These must raise the sticky error without disturbing any slot.

// File: rtl/thr_pkg.sv
package thr_pkg;
    typedef enum logic {
        TH_FREE = 1'b0,
        TH_BUSY = 1'b1
    } thr_state_e;
endpackage

// File: rtl/thr_slot.sv
module thr_slot
    import thr_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int DEST_W  = 2,
    parameter int CNT_MAX = 3,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              join_i,
    input  logic              retire_i,
    input  logic [ID_W-1:0]   new_id_i,
    input  logic [DEST_W-1:0] new_dest_i,
    output logic              busy_o,
    output logic              full_o,
    output logic [ID_W-1:0]   id_o,
    output logic [DEST_W-1:0] dest_o
);
    thr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ID_W-1:0]   id_q;
    logic [DEST_W-1:0] dest_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TH_FREE;
            cnt_q  <= '0;
            id_q   <= '0;
            dest_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (alloc_i && st_q == TH_FREE) begin
                id_q   <= new_id_i;
                dest_q <= new_dest_i;
            end
        end
    end

    // next state: T_ALLOC, T_JOIN, T_RETIRE, T_JOIN_RETIRE, T_DRAIN
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TH_FREE: begin
                if (alloc_i) begin
                    st_d  = TH_BUSY;
                    cnt_d = CNT_W'(1);
                end
            end
            TH_BUSY: begin
                if (join_i && !retire_i) begin
                    cnt_d = cnt_q + CNT_W'(1);
                end else if (retire_i && !join_i) begin
                    if (cnt_q == CNT_W'(1)) begin
                        st_d  = TH_FREE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: begin
                st_d  = TH_FREE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (st_q == TH_BUSY);
        full_o = (cnt_q == CNT_W'(CNT_MAX));
        id_o   = id_q;
        dest_o = dest_q;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX));
    p_free_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TH_FREE) |-> (cnt_q == '0));
    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TH_BUSY && cnt_q == CNT_W'(1) && retire_i && !join_i) |=> (st_q == TH_FREE));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TH_BUSY && retire_i && join_i) |=> (st_q == TH_BUSY && $stable(cnt_q)));
endmodule

// File: rtl/thr_match.sv
module thr_match #(
    parameter int NUM_THREADS = 4,
    parameter int ID_W        = 4,
    parameter int DEST_W      = 2
) (
    input  logic [NUM_THREADS-1:0] busy_i,
    input  logic [NUM_THREADS-1:0] full_i,
    input  logic [ID_W-1:0]        slot_id_i   [NUM_THREADS],
    input  logic [DEST_W-1:0]      slot_dest_i [NUM_THREADS],
    input  logic [ID_W-1:0]        req_id_i,
    input  logic [DEST_W-1:0]      req_dest_i,
    input  logic [ID_W-1:0]        cpl_id_i,
    output logic [NUM_THREADS-1:0] req_hit_o,
    output logic                   join_ok_o,
    output logic [NUM_THREADS-1:0] cpl_hit_o
);
    logic [NUM_THREADS-1:0] joinable;

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_cmp
        assign req_hit_o[i] = busy_i[i] && (slot_id_i[i] == req_id_i);
        assign cpl_hit_o[i] = busy_i[i] && (slot_id_i[i] == cpl_id_i);
        assign joinable[i]  = req_hit_o[i] && (slot_dest_i[i] == req_dest_i) && !full_i[i];
    end

    assign join_ok_o = |joinable;
endmodule

// File: rtl/thr_pick.sv
module thr_pick #(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0] busy_i,
    output logic [NUM_THREADS-1:0] grant_o,
    output logic                   any_free_o
);
    logic [NUM_THREADS:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_pri
        assign grant_o[i]  = !busy_i[i] && !seen[i];
        assign seen[i+1]   = seen[i] || !busy_i[i];
    end
    assign any_free_o = seen[NUM_THREADS];
endmodule

// File: rtl/axi_id_thread_gate.sv
module axi_id_thread_gate #(
    parameter int NUM_THREADS = 4,
    parameter int ID_W        = 4,
    parameter int DEST_W      = 2,
    parameter int CNT_MAX     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ID_W-1:0]        req_id,
    input  logic [DEST_W-1:0]      req_dest,
    output logic                   req_ready,
    input  logic                   cpl_valid,
    input  logic [ID_W-1:0]        cpl_id,
    output logic [NUM_THREADS-1:0] busy_map,
    output logic                   err_unmatched
);
    logic [NUM_THREADS-1:0] busy, full, req_hit, cpl_hit, grant;
    logic [NUM_THREADS-1:0] alloc_v, join_v, retire_v;
    logic [ID_W-1:0]        slot_id   [NUM_THREADS];
    logic [DEST_W-1:0]      slot_dest [NUM_THREADS];
    logic                   join_ok, any_free, any_hit, fire, err_q;

    thr_match #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W), .DEST_W(DEST_W)) u_match (
        .busy_i(busy), .full_i(full), .slot_id_i(slot_id), .slot_dest_i(slot_dest),
        .req_id_i(req_id), .req_dest_i(req_dest), .cpl_id_i(cpl_id),
        .req_hit_o(req_hit), .join_ok_o(join_ok), .cpl_hit_o(cpl_hit)
    );

    thr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
        .busy_i(busy), .grant_o(grant), .any_free_o(any_free)
    );

    always_comb begin
        any_hit   = |req_hit;
        req_ready = any_hit ? join_ok : any_free;
        fire      = req_valid && req_ready;
        alloc_v   = (fire && !any_hit) ? grant   : '0;
        join_v    = (fire &&  any_hit) ? req_hit : '0;
        retire_v  = cpl_valid ? cpl_hit : '0;
    end

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_slot
        thr_slot #(.ID_W(ID_W), .DEST_W(DEST_W), .CNT_MAX(CNT_MAX)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_v[i]), .join_i(join_v[i]), .retire_i(retire_v[i]),
            .new_id_i(req_id), .new_dest_i(req_dest),
            .busy_o(busy[i]), .full_o(full[i]),
            .id_o(slot_id[i]), .dest_o(slot_dest[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (cpl_valid && !(|cpl_hit)) err_q <= 1'b1;
    end

    assign busy_map      = busy;
    assign err_unmatched = err_q;

    p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_hit));
    p_single_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_v));
    p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_stray_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !(|cpl_hit) && !fire) |=> $stable(busy));
endmodule

// File: tb/tb_axi_id_thread_gate.sv
module tb_axi_id_thread_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NV = 23;

    logic clk = 1'b0;
    logic rst_n, req_valid, cpl_valid, req_ready, err_unmatched;
    logic [3:0] req_id, cpl_id, busy_map;
    logic [1:0] req_dest;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_id_thread_gate #(.NUM_THREADS(NT), .ID_W(4), .DEST_W(2), .CNT_MAX(3)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_dest(req_dest), .req_ready(req_ready), .cpl_valid(cpl_valid),
        .cpl_id(cpl_id), .busy_map(busy_map), .err_unmatched(err_unmatched)
    );

    // fields: rv, id, dest, cv, cid, exp_ready, exp_busy_after, exp_err_after
    localparam logic [17:0] VEC [NV] = '{
        {1'b1,4'd1,2'd0, 1'b0,4'd0, 1'b1,4'b0001,1'b0}, // 0  R2 first alloc slot0
        {1'b1,4'd1,2'd0, 1'b0,4'd0, 1'b1,4'b0001,1'b0}, // 1  R3 join cnt2
        {1'b1,4'd1,2'd0, 1'b0,4'd0, 1'b1,4'b0001,1'b0}, // 2  R3 join cnt3
        {1'b1,4'd1,2'd0, 1'b0,4'd0, 1'b0,4'b0001,1'b0}, // 3  R3 saturated
        {1'b1,4'd1,2'd2, 1'b0,4'd0, 1'b0,4'b0001,1'b0}, // 4  R4 other dest
        {1'b1,4'd2,2'd1, 1'b0,4'd0, 1'b1,4'b0011,1'b0}, // 5  R9
        {1'b1,4'd3,2'd2, 1'b0,4'd0, 1'b1,4'b0111,1'b0}, // 6  R9
        {1'b1,4'd4,2'd3, 1'b0,4'd0, 1'b1,4'b1111,1'b0}, // 7  R9
        {1'b1,4'd5,2'd0, 1'b0,4'd0, 1'b0,4'b1111,1'b0}, // 8  R5 pool full
        {1'b0,4'd0,2'd0, 1'b1,4'd3, 1'b0,4'b1011,1'b0}, // 9  R6 R9 middle drains
        {1'b1,4'd5,2'd0, 1'b0,4'd0, 1'b1,4'b1111,1'b0}, // 10 R2 hole reuse
        {1'b0,4'd0,2'd0, 1'b1,4'd1, 1'b0,4'b1111,1'b0}, // 11 R6 cnt2
        {1'b1,4'd1,2'd0, 1'b1,4'd1, 1'b1,4'b1111,1'b0}, // 12 R7 cnt stays 2
        {1'b0,4'd0,2'd0, 1'b1,4'd1, 1'b0,4'b1111,1'b0}, // 13 R6 cnt1
        {1'b1,4'd1,2'd2, 1'b0,4'd0, 1'b0,4'b1111,1'b0}, // 14 R4 still busy
        {1'b0,4'd0,2'd0, 1'b1,4'd1, 1'b0,4'b1110,1'b0}, // 15 R6 drain slot0
        {1'b1,4'd1,2'd2, 1'b0,4'd0, 1'b1,4'b1111,1'b0}, // 16 R4 rebind
        {1'b0,4'd0,2'd0, 1'b1,4'd9, 1'b0,4'b1111,1'b1}, // 17 R8 stray
        {1'b0,4'd0,2'd0, 1'b0,4'd0, 1'b0,4'b1111,1'b1}, // 18 R8 sticky
        {1'b0,4'd0,2'd0, 1'b1,4'd2, 1'b0,4'b1101,1'b1}, // 19 R6
        {1'b0,4'd0,2'd0, 1'b1,4'd2, 1'b0,4'b1101,1'b1}, // 20 R8 repeat
        {1'b1,4'd4,2'd3, 1'b1,4'd4, 1'b1,4'b1101,1'b1}, // 21 R7 at cnt1
        {1'b0,4'd0,2'd0, 1'b1,4'd4, 1'b0,4'b0101,1'b1}  // 22 R6
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [17:0] v, input int idx);
        req_valid = v[17]; req_id = v[16:13]; req_dest = v[12:11];
        cpl_valid = v[10]; cpl_id = v[9:6];
        #1;
        if (v[17]) check($sformatf("R2-5 ready row %0d", idx), int'(req_ready), int'(v[5]));
        @(negedge clk);
        check($sformatf("R6 busy_map row %0d", idx), int'(busy_map), int'(v[4:1]));
        check($sformatf("R8 err row %0d", idx), int'(err_unmatched), int'(v[0]));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
        req_id = '0; req_dest = '0; cpl_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy after reset", int'(busy_map), 0);
        check("R1 err after reset", int'(err_unmatched), 0);
        for (int i = 0; i < NV; i++) step(VEC[i], i);

        // R1: reset in the middle clears all state
        req_valid = 1'b0; cpl_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy after mid reset", int'(busy_map), 0);
        check("R1 err after mid reset", int'(err_unmatched), 0);
        req_valid = 1'b1; req_id = 4'd7; req_dest = 2'd3;
        #1;
        check("R1 ready after mid reset", int'(req_ready), 1);
        @(negedge clk);
        check("R2 alloc slot0 after mid reset", int'(busy_map), 1);
        req_valid = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule